// File: doc/BRIEF.md
# Per-Lane Elastic Bit Store

This block is a small bit-wide elastic buffer for a single parallel lane that feeds a bit-interleaving multiplexer. Bits arrive with a write strobe whose timing wanders relative to the reference-derived read strobe. They are held in a ring of `DEPTH` one-bit cells, ten by default, and are read back in the order they were written. A write pointer and a read pointer move independently around the ring, and both wrap modulo `DEPTH`.

An active-low centring input re-centres the store. When this input is released, the read pointer is placed half the ring behind the write pointer. The store then holds half its capacity, so it can absorb drift of almost half the depth in either direction. Data should already be flowing before the centring pulse is released. Until the first centring after reset, the read side stays quiet, because the store has not yet been given its full skew range. A collision between the pointers sets a sticky error flag. A collision is a write into a full store or a read from an empty one.

Both sides are modelled inside one clock domain: the write and read timing are carried by their enables. The block has a synchronous active-high reset.

Top module: `lane_elastic_store`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears. After that edge, `rd_valid` is 0 and `err` is 0.
- R2: Until the first centring after reset, `rd_valid` and `err` stay 0 whatever the enables do. Writes are still stored.
- R3: A centring takes place in the first cycle in which `center_n` is sampled high after being sampled low. In that cycle no read is performed, and a write in that cycle is still stored. The fill level becomes `DEPTH/2`. The next bit read is the one written `DEPTH/2` accepted writes back, counting the write made in the centring cycle.
- R4: A read request on a non-empty centred store presents the oldest unread bit on `rd_bit`, with `rd_valid` high, on the edge after the request. If `rd_en` was low, `rd_valid` is low after that edge.
- R5: After a centring, the bits come out in the same order as the accepted writes, with none lost or repeated. A write/read phase offset that drifts by up to ±(`DEPTH/2`-1) positions raises no error.
- R6: A write while the store holds `DEPTH` bits, with no successful read in the same cycle, is dropped and sets `err`. A write and a read in the same cycle at full level both succeed with no error.
- R7: A read request while the store is empty returns no data, which means `rd_valid` is 0 after that edge, and sets `err`.
- R8: `err` stays high until the next centring or reset clears it. Further traffic does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both the write and read strobes |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the lane's skewed timing |
| wr_bit | input | 1 | Data bit written when `wr_en` is high |
| rd_en | input | 1 | Read strobe from the reference timing |
| center_n | input | 1 | Active-low centring pulse; the store re-centres on its release |
| rd_bit | output | 1 | Registered output bit toward the multiplexer |
| rd_valid | output | 1 | High when `rd_bit` carries a bit read on the previous edge |
| err | output | 1 | Sticky pointer-collision flag (overflow or underflow) |

## Verification
The hardest situation to reach from the ports is a drift that takes the store right to the edge of its range, one short of a collision, and then back through the centre. That drift must never raise `err`, and the bit order must survive. The stimulus reaches it by sweeping the drift amplitude from 1 to `DEPTH/2`-1. Each amplitude is produced with runs of write-only and read-only cycles between balanced stretches, and idle cycles are interleaved in those stretches. A second hard point is the pointer relation at centring. To cover it, the bench writes more than `DEPTH/2` bits before each release, and it keeps writing during the release cycle. The first bit read must then be the one written exactly `DEPTH/2` accepted writes earlier.

// File: rtl/es_pkg.sv
package es_pkg;

  // forward step around a ring of d cells
  function automatic int wrap_fwd(int p, int n, int d);
    return (p + n) % d;
  endfunction

  // backward step around a ring of d cells
  function automatic int wrap_back(int p, int n, int d);
    return (p + d - (n % d)) % d;
  endfunction

endpackage

// File: rtl/es_edge.sv
module es_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_n,
  output logic rise
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b1;
    else     q <= sig_n;
  end

  assign rise = sig_n & ~q;
endmodule

// File: rtl/es_ptr.sv
module es_ptr #(
  parameter int DEPTH = 10,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] ptr_nxt
);
  assign ptr_nxt = adv ? PW'(es_pkg::wrap_fwd(int'(ptr), 1, DEPTH)) : ptr;

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else           ptr <= ptr_nxt;
  end
endmodule

// File: rtl/es_store.sv
module es_store #(
  parameter int DEPTH = 10,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic          wdata,
  input  logic          re,
  input  logic [PW-1:0] raddr,
  output logic          rdata
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lane_elastic_store.sv
module lane_elastic_store #(
  parameter int DEPTH = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_en,
  input  logic center_n,
  output logic rd_bit,
  output logic rd_valid,
  output logic err
);
  localparam int PW     = $clog2(DEPTH);
  localparam int LW     = $clog2(DEPTH + 1);
  localparam int OFFSET = DEPTH / 2;

  logic          rise;
  logic          centred;
  logic          act;
  logic          rd_ok;
  logic          wr_ok;
  logic          under;
  logic          over;
  logic [LW-1:0] lvl;
  logic [PW-1:0] wp, wp_nxt;
  logic [PW-1:0] rp, rp_nxt;
  logic [PW-1:0] rp_centre;

  es_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .sig_n (center_n),
    .rise  (rise)
  );

  // normal operation only once centred, and never in the centring cycle
  assign act   = centred & ~rise;
  assign rd_ok = act & rd_en & (lvl != '0);
  assign under = act & rd_en & (lvl == '0);
  assign wr_ok = wr_en & (~act | (lvl != LW'(DEPTH)) | rd_ok);
  assign over  = wr_en & ~wr_ok;

  es_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
    .clk      (clk),
    .rst      (rst),
    .adv      (wr_ok),
    .load     (1'b0),
    .load_val ('0),
    .ptr      (wp),
    .ptr_nxt  (wp_nxt)
  );

  // read pointer lands half the ring behind the post-write position
  assign rp_centre = PW'(es_pkg::wrap_back(int'(wp_nxt), OFFSET, DEPTH));

  es_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
    .clk      (clk),
    .rst      (rst),
    .adv      (rd_ok),
    .load     (rise),
    .load_val (rp_centre),
    .ptr      (rp),
    .ptr_nxt  (rp_nxt)
  );

  es_store #(.DEPTH(DEPTH), .PW(PW)) u_mem (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wp),
    .wdata (wr_bit),
    .re    (rd_ok),
    .raddr (rp),
    .rdata (rd_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      centred  <= 1'b0;
      lvl      <= '0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      if (rise) begin
        centred <= 1'b1;
        lvl     <= LW'(OFFSET);
        err     <= 1'b0;
      end else if (act) begin
        case ({wr_ok, rd_ok})
          2'b10:   lvl <= lvl + 1'b1;
          2'b01:   lvl <= lvl - 1'b1;
          default: lvl <= lvl;
        endcase
        if (under | over) err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/es_chk.sv
module es_chk #(
  parameter int DEPTH = 10
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         center_n,
  input logic                         rd_en,
  input logic                         rd_valid,
  input logic                         err,
  input logic [$clog2(DEPTH+1)-1:0]   lvl
);
  localparam int OFFSET = DEPTH / 2;

  logic prev_c;
  logic seen;
  logic rise_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_c <= 1'b1;
      seen   <= 1'b0;
    end else begin
      prev_c <= center_n;
      if (rise_c) seen <= 1'b1;
    end
  end

  assign rise_c = center_n & ~prev_c;

  p_precentre_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (!rd_valid && !err));

  p_centre_level_r3: assert property (@(posedge clk) disable iff (rst)
    rise_c |=> (int'(lvl) == OFFSET));

  p_no_read_no_valid_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  p_level_bound_r5: assert property (@(posedge clk) disable iff (rst)
    int'(lvl) <= DEPTH);

  p_centre_clears_r8: assert property (@(posedge clk) disable iff (rst)
    rise_c |=> !err);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err && !rise_c) |=> err);
endmodule

bind lane_elastic_store es_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .center_n (center_n),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .err      (err),
  .lvl      (lvl)
);

// File: tb/sim_lane_elastic_store.sv
module sim_lane_elastic_store;
  localparam int DEPTH = 10;
  localparam int OFF   = DEPTH / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0, center_n = 1'b1;
  logic rd_bit, rd_valid, err;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit   hist [4096];
  int   m_nw = 0;
  int   m_ridx = 0;
  int   m_lvl = 0;
  bit   m_cent = 0;
  bit   m_err = 0;
  bit   c_prev = 1;
  int   att = 0;

  lane_elastic_store #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bit(wr_bit),
    .rd_en(rd_en), .center_n(center_n),
    .rd_bit(rd_bit), .rd_valid(rd_valid), .err(err)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; rd_en = 0; center_n = 1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    m_cent = 0; m_lvl = 0; m_err = 0; c_prev = 1;
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    chk(err == 1'b0, "R1 err after reset", int'(err), 0);
  endtask

  task automatic cyc(input bit w, input bit r, input bit c, input string tag);
    bit wb, rise, act, rok, under, wok, eb;
    wb = (^(att[5:0] & 6'b101101)) ^ att[7];
    att++;
    wr_en = w; wr_bit = wb; rd_en = r; center_n = c;
    rise = c & ~c_prev;
    c_prev = c;
    act = m_cent & ~rise;
    rok = act & r & (m_lvl != 0);
    under = act & r & (m_lvl == 0);
    wok = w & (!act || m_lvl != DEPTH || rok);
    eb = rok ? hist[m_ridx % 4096] : 1'b0;
    if (wok) begin hist[m_nw % 4096] = wb; m_nw++; end
    if (rok) m_ridx++;
    if (rise) begin
      m_cent = 1; m_ridx = m_nw - OFF; m_lvl = OFF; m_err = 0;
    end else if (act) begin
      m_lvl = m_lvl + int'(wok) - int'(rok);
      if (under || (w && !wok)) m_err = 1;
    end
    @(posedge clk);
    #1;
    chk(rd_valid == rok, {tag, " rd_valid"}, int'(rd_valid), int'(rok));
    if (rok) chk(rd_bit == eb, {tag, " rd_bit order"}, int'(rd_bit), int'(eb));
    chk(err == m_err, {tag, " err"}, int'(err), int'(m_err));
  endtask

  // centring: low pulse then release, writes continue throughout (R3)
  task automatic centre(input string tag);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, tag);
    cyc(1, 1, 1, tag);
  endtask

  task automatic balanced(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (i % 3 == 2) cyc(0, 0, 1, tag);
      else            cyc(1, 1, 1, tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();

    // R2: before centring, no output and no error, even with reads on empty
    for (int i = 0; i < 14; i++) cyc(1'(i % 2), 1, 1, "R2 precentre");
    cyc(0, 1, 1, "R2 precentre read");

    // R3: first centring; first reads follow the half-depth offset
    centre("R3 centring");
    for (int i = 0; i < 6; i++) cyc(1, 1, 1, "R3 first reads");

    // R5: drift sweep over every amplitude inside the safe range
    for (int a = 1; a < OFF; a++) begin
      centre("R5 recentre");
      balanced(9, "R5 steady");
      for (int i = 0; i < a; i++) cyc(1, 0, 1, "R5 drift up");
      balanced(7, "R5 high");
      for (int i = 0; i < 2 * a; i++) cyc(0, 1, 1, "R5 drift down");
      balanced(7, "R5 low");
      for (int i = 0; i < a; i++) cyc(1, 0, 1, "R5 back");
      balanced(6, "R5 settle");
      chk(err == 1'b0, "R5 no error after drift", int'(err), 0);
    end

    // R6: fill to full, one simultaneous write/read at full, then overflow
    centre("R6 recentre");
    for (int i = 0; i < OFF; i++) cyc(1, 0, 1, "R6 fill");
    cyc(1, 1, 1, "R6 full both");
    chk(err == 1'b0, "R6 no error at full with read", int'(err), 0);
    cyc(1, 0, 1, "R6 overflow");
    chk(err == 1'b1, "R6 overflow flag", int'(err), 1);

    // R8: sticky through traffic, cleared by centring
    balanced(8, "R8 sticky");
    chk(err == 1'b1, "R8 still set", int'(err), 1);
    centre("R8 clear");
    chk(err == 1'b0, "R8 cleared by centring", int'(err), 0);

    // R7: drain past empty
    for (int i = 0; i < OFF + 1; i++) cyc(0, 1, 1, "R7 drain");
    chk(err == 1'b1, "R7 underflow flag", int'(err), 1);
    chk(rd_valid == 1'b0, "R7 no data on underflow", int'(rd_valid), 0);

    // R1: reset mid-run clears the flag; R2 again afterwards
    do_reset();
    for (int i = 0; i < 8; i++) cyc(1, 1, 1, "R2 after reset");
    centre("R3 after reset");
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, "R7 drain after reset");

    // R4: read strobe low gives no valid
    cyc(1, 0, 1, "R4 no read");
    chk(rd_valid == 1'b0, "R4 idle read", int'(rd_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule